// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is an up-counting interval timer with a small synchronous register port. Software loads two compare limits, presets the count if needed, and then starts the timer through a control word. On each tick while the timer runs, the count goes up by one. The terminal tick is a tick that arrives while the count already equals the active limit. On the terminal tick the count returns to zero, a sticky completion flag is set and, if enabled, an interrupt request becomes pending. The request then waits for an acknowledge pulse.

In single mode only limit A is used. In dual mode the timer takes turns between limit A and limit B, and a readable flag shows which one is active. Free-running operation repeats the cycle. One-shot operation stops the timer at the end of the last phase of a cycle: A in single mode, B in dual mode. The run bit is guarded. A write changes it only when a key bit is set in the same word, so a careless write to the other control fields cannot start or stop the timer.

Register map by word address: 0 control, 1 count, 2 limit A, 3 limit B. Reads are registered and appear on `bus_rdata` one clock after the address is presented.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the control word, count, both limits and `irq` are all zero.
- R2: Address 0 reads control, 1 the count, 2 limit A and 3 limit B; `bus_rdata` shows the value for the address sampled at the previous clock edge; writes to addresses 1 to 3 load that register.
- R3: A control write changes the run bit (bit 15) only when bit 14 of the same write is 1; without it the run bit keeps its value while bits 13, 1 and 0 still take the written values.
- R4: The control word reads run in bit 15, interrupt-enable in 13, active-limit flag in 12, completion flag in 5, dual-mode in 1 and free-run in 0; bit 14 and all other bits read 0.
- R5: With the run bit 1 each tick adds one to the count; with it 0 ticks leave the count unchanged.
- R6: A tick while running with the count equal to the active limit is a terminal tick: the count becomes 0 and the completion flag is set. This includes a count and limit of FFFFh.
- R7: With dual-mode 0 only limit A is compared and the active-limit flag reads 0, whatever limit B holds.
- R8: With dual-mode 1 each terminal tick switches the active limit between A (flag 0) and B (flag 1), starting from A.
- R9: With interrupt-enable 1 every terminal tick, on A and on B, makes `irq` 1 from the next cycle; with it 0 no terminal tick raises `irq`.
- R10: Once set, `irq` stays 1 until an `irq_ack` pulse, even if the run bit is cleared meanwhile; a new request in the same cycle as an acknowledge wins.
- R11: With free-run 0 the run bit clears itself on the terminal tick of limit A in single mode and of limit B in dual mode; a terminal tick on A in dual mode leaves it running.
- R12: A control write with bit 5 at 0 clears the completion flag, a write with bit 5 at 1 leaves it as it is, and a terminal tick sets it regardless of a write in the same cycle.
- R13: A count write in the same cycle as a counting tick loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count advance strobe, one cycle per count |
| irq_ack | input | 1 | Acknowledge pulse that clears the pending request |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Pending interrupt request |

## Verification
The bench builds the timer with its default 16-bit count and data widths. This keeps the limit-A, limit-B and count registers full width. A preset count of FFFEh against a limit of FFFFh can then reach the top-of-range terminal tick in two ticks. Small limits, including zero, keep full single and dual cycles short enough that the table can walk many phase and wrap positions. Those same small limits drive the directed runs for one-shot stops, interrupt hold and the guarded run bit.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int REG_CTRL  = 0;
  localparam int REG_COUNT = 1;
  localparam int REG_LIMA  = 2;
  localparam int REG_LIMB  = 3;

  localparam int B_RUN  = 15;
  localparam int B_KEY  = 14;
  localparam int B_IEN  = 13;
  localparam int B_SEL  = 12;
  localparam int B_DONE = 5;
  localparam int B_DUAL = 1;
  localparam int B_FREE = 0;
endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic w_run,
  input  logic w_key,
  input  logic w_ien,
  input  logic w_done,
  input  logic w_dual,
  input  logic w_free,
  input  logic term,
  output logic run,
  output logic ien,
  output logic sel_b,
  output logic done,
  output logic dual,
  output logic free
);
  logic last_phase;
  logic dual_nx;

  assign last_phase = term && !free && (!dual || sel_b);
  assign dual_nx    = wr ? w_dual : dual;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      ien   <= 1'b0;
      sel_b <= 1'b0;
      done  <= 1'b0;
      dual  <= 1'b0;
      free  <= 1'b0;
    end else begin
      if (wr && w_key)
        run <= w_run;
      else if (last_phase)
        run <= 1'b0;

      if (wr) begin
        ien  <= w_ien;
        dual <= w_dual;
        free <= w_free;
      end

      if (!dual_nx)
        sel_b <= 1'b0;
      else if (term && dual)
        sel_b <= ~sel_b;

      if (term)
        done <= 1'b1;
      else if (wr && !w_done)
        done <= 1'b0;
    end
  end

  // R3: run bit untouched by an unkeyed write when no terminal tick
  a_r3_run_guard: assert property (@(posedge clk) disable iff (rst)
    (wr && !w_key && !term) |=> $stable(run));
  // R7: single mode keeps limit A selected
  a_r7_single_sel: assert property (@(posedge clk) disable iff (rst)
    !dual |-> !sel_b);
  // R12: terminal tick always sets the completion flag
  a_r12_done_set: assert property (@(posedge clk) disable iff (rst)
    term |=> done);
  // R11: single one-shot stops on its terminal tick
  a_r11_oneshot: assert property (@(posedge clk) disable iff (rst)
    (term && !free && !dual && !(wr && w_key)) |=> !run);
endmodule

// File: rtl/dct_core.sv
module dct_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             sel_b,
  input  logic             wr_cnt,
  input  logic             wr_lima,
  input  logic             wr_limb,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] lim_a,
  output logic [CNT_W-1:0] lim_b,
  output logic             term
);
  logic [CNT_W-1:0] active;

  assign active = sel_b ? lim_b : lim_a;
  assign term   = tick && run && (count == active);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      lim_a <= '0;
      lim_b <= '0;
    end else begin
      if (wr_lima) lim_a <= wval;
      if (wr_limb) lim_b <= wval;
      if (wr_cnt)
        count <= wval;
      else if (term)
        count <= '0;
      else if (tick && run)
        count <= count + 1'b1;
    end
  end

  // R5: a stopped timer holds its count
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_cnt) |=> $stable(count));
  // R6: terminal tick returns the count to zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (term && !wr_cnt) |=> (count == '0));
  // R13: a count write is taken over a tick
  a_r13_load: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (count == $past(wval)));
endmodule

// File: rtl/dct_irq.sv
module dct_irq (
  input  logic clk,
  input  logic rst,
  input  logic term,
  input  logic ien,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)
      pend <= 1'b0;
    else if (term && ien)
      pend <= 1'b1;
    else if (ack)
      pend <= 1'b0;
  end

  // R10: request holds until acknowledged
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);
  // R10: new request beats an acknowledge
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (term && ien) |=> pend);
  // R9: nothing raised while interrupts are off
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (!pend && !ien) |=> !pend);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              irq_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             wr_ctrl, wr_cnt, wr_lima, wr_limb;
  logic             run, ien, sel_b, done, dual, free, term;
  logic [CNT_W-1:0] count, lim_a, lim_b;
  logic [DATA_W-1:0] ctrl_word;
  logic             unused_wbits;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(REG_COUNT));
  assign wr_lima = bus_we && (bus_addr == ADDR_W'(REG_LIMA));
  assign wr_limb = bus_we && (bus_addr == ADDR_W'(REG_LIMB));
  assign unused_wbits = ^{bus_wdata[11:6], bus_wdata[4:2]};

  dct_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr     (wr_ctrl),
    .w_run  (bus_wdata[B_RUN]),
    .w_key  (bus_wdata[B_KEY]),
    .w_ien  (bus_wdata[B_IEN]),
    .w_done (bus_wdata[B_DONE]),
    .w_dual (bus_wdata[B_DUAL]),
    .w_free (bus_wdata[B_FREE]),
    .term   (term),
    .run    (run),
    .ien    (ien),
    .sel_b  (sel_b),
    .done   (done),
    .dual   (dual),
    .free   (free)
  );

  dct_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .run     (run),
    .sel_b   (sel_b),
    .wr_cnt  (wr_cnt),
    .wr_lima (wr_lima),
    .wr_limb (wr_limb),
    .wval    (bus_wdata[CNT_W-1:0]),
    .count   (count),
    .lim_a   (lim_a),
    .lim_b   (lim_b),
    .term    (term)
  );

  dct_irq u_irq (
    .clk  (clk),
    .rst  (rst),
    .term (term),
    .ien  (ien),
    .ack  (irq_ack),
    .pend (irq)
  );

  always_comb begin
    ctrl_word         = '0;
    ctrl_word[B_RUN]  = run;
    ctrl_word[B_IEN]  = ien;
    ctrl_word[B_SEL]  = sel_b;
    ctrl_word[B_DONE] = done;
    ctrl_word[B_DUAL] = dual;
    ctrl_word[B_FREE] = free;
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else begin
      case (int'(bus_addr))
        REG_CTRL:  bus_rdata <= ctrl_word;
        REG_COUNT: bus_rdata <= DATA_W'(count);
        REG_LIMA:  bus_rdata <= DATA_W'(lim_a);
        REG_LIMB:  bus_rdata <= DATA_W'(lim_b);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R4: key bit never reads back
  a_r4_key_zero: assert property (@(posedge clk) disable iff (rst)
    ((bus_addr == ADDR_W'(REG_CTRL)) && (DATA_W > B_KEY)) |=> !bus_rdata[B_KEY]);
endmodule

// File: tb/tb_dual_cmp_timer.sv
`timescale 1ns/1ps
module tb_dual_cmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        irq_ack = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  dual_cmp_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .irq_ack(irq_ack),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] la;
    logic [15:0] lb;
    logic        dualm;
    logic [7:0]  nt;
    logic [15:0] ecnt;
    logic        esel;
    logic        edone;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'd3, 16'd0, 1'b0, 8'd2, 16'd2, 1'b0, 1'b0},
    '{16'd3, 16'd0, 1'b0, 8'd4, 16'd0, 1'b0, 1'b1},
    '{16'd3, 16'd0, 1'b0, 8'd6, 16'd2, 1'b0, 1'b1},
    '{16'd2, 16'd4, 1'b1, 8'd3, 16'd0, 1'b1, 1'b1},
    '{16'd2, 16'd4, 1'b1, 8'd8, 16'd0, 1'b0, 1'b1},
    '{16'd2, 16'd4, 1'b1, 8'd5, 16'd2, 1'b1, 1'b1},
    '{16'd0, 16'd0, 1'b0, 8'd3, 16'd0, 1'b0, 1'b1},
    '{16'd2, 16'd1, 1'b0, 8'd2, 16'd2, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk);
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(posedge clk);
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    rd(2'd0, rv); check("R1 ctrl", rv, 16'h0000);
    rd(2'd1, rv); check("R1 count", rv, 16'h0000);
    rd(2'd2, rv); check("R1 limA", rv, 16'h0000);
    rd(2'd3, rv); check("R1 limB", rv, 16'h0000);

    // Table: R6 R7 R8 R5 with free-run, interrupts off
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, 16'h4000);
      wr(2'd1, 16'h0000);
      wr(2'd2, VECS[v].la);
      wr(2'd3, VECS[v].lb);
      wr(2'd0, 16'hC001 | {14'd0, VECS[v].dualm, 1'b0});
      ticks(int'(VECS[v].nt));
      rd(2'd1, rv); check($sformatf("R6/R8 count vec%0d", v), rv, VECS[v].ecnt);
      rd(2'd0, rv);
      check($sformatf("R7/R8 sel vec%0d", v), {15'd0, rv[12]}, {15'd0, VECS[v].esel});
      check($sformatf("R6 done vec%0d", v), {15'd0, rv[5]}, {15'd0, VECS[v].edone});
    end

    // R2 limit readback
    rd(2'd2, rv); check("R2 limA", rv, 16'd2);
    rd(2'd3, rv); check("R2 limB", rv, 16'd1);

    // R3 R4 R5 guarded run bit
    wr(2'd0, 16'h4000);
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd100);
    wr(2'd0, 16'h8001);
    rd(2'd0, rv); check("R3 unkeyed start", rv, 16'h0001);
    ticks(1);
    rd(2'd1, rv); check("R5 frozen", rv, 16'd5);
    wr(2'd0, 16'hC001);
    rd(2'd0, rv); check("R4 keyed start, key reads 0", rv, 16'h8001);
    wr(2'd0, 16'h0000);
    rd(2'd0, rv); check("R3 unkeyed stop ignored", rv, 16'h8000);
    ticks(1);
    rd(2'd1, rv); check("R5 counts", rv, 16'd6);

    // R9 R10 interrupt
    wr(2'd0, 16'h4000);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'hE001);
    ticks(1);
    check("R9 no early irq", {15'd0, irq}, 16'd0);
    ticks(1);
    check("R9 irq raised", {15'd0, irq}, 16'd1);
    wr(2'd0, 16'h4000);
    check("R10 irq held after stop", {15'd0, irq}, 16'd1);
    ack();
    check("R10 irq cleared by ack", {15'd0, irq}, 16'd0);
    wr(2'd0, 16'hC001);
    ticks(2);
    check("R9 no irq when disabled", {15'd0, irq}, 16'd0);
    rd(2'd0, rv); check("R12 done set", rv, 16'h8021);
    wr(2'd0, 16'hC021);
    rd(2'd0, rv); check("R12 write 1 keeps done", rv, 16'h8021);
    wr(2'd0, 16'hC001);
    rd(2'd0, rv); check("R12 write 0 clears done", rv, 16'h8001);

    // R10 set wins over ack in same cycle
    wr(2'd0, 16'h4000);
    wr(2'd1, 16'd1);
    wr(2'd0, 16'hE001);
    ticks(1);
    check("R10 pending", {15'd0, irq}, 16'd1);
    wr(2'd1, 16'd1);
    @(negedge clk); tick = 1'b1; irq_ack = 1'b1;
    @(posedge clk);
    @(negedge clk); tick = 1'b0; irq_ack = 1'b0;
    check("R10 set beats ack", {15'd0, irq}, 16'd1);
    ack();

    // R8 R9 dual-mode interrupts on both limits
    wr(2'd0, 16'h4000);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd1);
    wr(2'd3, 16'd2);
    wr(2'd0, 16'hE003);
    ticks(2);
    check("R9 irq on limit A", {15'd0, irq}, 16'd1);
    rd(2'd0, rv); check("R8 sel B after A", rv, 16'hB023);
    ack();
    ticks(3);
    check("R9 irq on limit B", {15'd0, irq}, 16'd1);
    rd(2'd0, rv); check("R8 sel A after B", rv, 16'hA023);
    ack();

    // R11 one-shot single
    wr(2'd0, 16'h4000);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'hC000);
    ticks(3);
    rd(2'd0, rv); check("R11 single stops", rv, 16'h0020);
    ticks(2);
    rd(2'd1, rv); check("R11 stays stopped", rv, 16'd0);

    // R11 one-shot dual
    wr(2'd0, 16'h4000);
    wr(2'd2, 16'd1);
    wr(2'd3, 16'd1);
    wr(2'd0, 16'hC002);
    ticks(2);
    rd(2'd0, rv); check("R11 dual runs past A", rv, 16'h9022);
    ticks(2);
    rd(2'd0, rv); check("R11 dual stops after B", rv, 16'h0022);

    // R6 top of range
    wr(2'd0, 16'h4000);
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'hFFFE);
    wr(2'd0, 16'hC001);
    ticks(1);
    rd(2'd1, rv); check("R6 reaches FFFF", rv, 16'hFFFF);
    ticks(1);
    rd(2'd1, rv); check("R6 wraps from FFFF", rv, 16'h0000);
    rd(2'd0, rv); check("R6 done at FFFF", rv, 16'h8021);

    // R13 count write beats tick
    @(negedge clk);
    tick = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0010; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
    rd(2'd1, rv); check("R13 write over tick", rv, 16'h0010);

    finished = 1;
    summary();
    $finish;
  end
endmodule